// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block merges the interrupt causes of a 16550-style serial port into a single interrupt request line and an 8-bit identification byte. Five causes compete under a fixed ranking: receive line errors, character timeout, receive data available, transmit holding register empty, and modem status change. Each cause is gated by its own enable bit. The winning cause is encoded in the low nibble of the identification byte. The high nibble reports whether the FIFOs are switched on.

The status flags come from the receiver, the FIFOs and the modem-line logic that surround the block. Most of them are taken as level inputs. The exception is the transmit-empty cause. Its pending flag lives inside this block and is driven by register-access strobes. It is set when the transmitter drains, or when the enable register is written while the holding register is empty. It is cleared when software reads the identification byte or writes the holding register.

The encoding and the request line are combinational from the inputs and the pending flag. A register access therefore changes the outputs one cycle after its strobe.

Top module: `uart_irq_prio`

## Requirements
- R1: When several causes are active together, `idCode[3:0]` shows the highest-ranked one. The ranking from highest to lowest, with codes, is: line error 0x6, character timeout 0xC, receive data 0x4, transmit empty 0x2, modem change 0x0.
- R2: The line error cause is active when `ierValue[2]` is 1 and at least one bit of `lineErr[3:0]` is 1. The four bits are overrun, parity, framing and break.
- R3: The character timeout cause is active only when `ierValue[0]` (receive data enable) is 1 and `timeoutPend` is 1. With `ierValue[0]` at 0, a pending timeout never produces code 0xC.
- R4: The receive data cause has two conditions. With `fifoOn` at 0, it needs `ierValue[0]` and `dataReady`. With `fifoOn` at 1, it also needs `rxCount >= rxTrigger`.
- R5: The transmit empty cause is active when `ierValue[1]` is 1 and the internal pending flag is set.
- R6: The modem change cause is active when `ierValue[3]` is 1 and at least one bit of `modemDelta[3:0]` is 1.
- R7: With no cause active, `idCode[3:0]` is 0x1 and `irqOut` is 0. `irqOut` is 1 exactly when some cause is selected.
- R8: `idCode[7:4]` is 0xC while `fifoOn` is 1 and 0x0 otherwise.
- R9: The pending flag is set on the clock edge that samples `txDrained` high. It is also set on the edge that samples `ierWrite` high while `thrEmpty` is 1. The effect is visible in the following cycle.
- R10: The pending flag is cleared on the edge that samples `idRead` or `thrWrite` high. If a set condition occurs in the same cycle, the set wins. During the read cycle itself, `idCode` still shows the value from before the read.
- R11: Synchronous reset clears the pending flag. After reset, with all inputs at 0, `idCode` is 0x01 and `irqOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ierValue | input | 4 | Enables: bit0 receive data/timeout, bit1 transmit empty, bit2 line error, bit3 modem |
| lineErr | input | 4 | Overrun, parity, framing and break status bits |
| dataReady | input | 1 | Receive data ready flag |
| fifoOn | input | 1 | FIFOs enabled |
| rxCount | input | CNT_W | Receive FIFO fill level |
| rxTrigger | input | CNT_W | Receive FIFO trigger level |
| timeoutPend | input | 1 | Character timeout pending |
| modemDelta | input | 4 | Modem line change bits |
| thrEmpty | input | 1 | Holding register empty status |
| txDrained | input | 1 | Strobe: transmitter has drained |
| ierWrite | input | 1 | Strobe: enable register written |
| idRead | input | 1 | Strobe: identification byte read |
| thrWrite | input | 1 | Strobe: holding register written |
| idCode | output | 8 | Identification byte |
| irqOut | output | 1 | Interrupt request |

## Verification
Directed cases cover the following situations:
- All five causes raised at once, then removed one by one. This shows that each rank hides the ranks below it.
- A pending timeout with its enable cleared. This separates the masked timeout from a plain receive-data gate.
- A FIFO fill level one below and then exactly at the trigger level. This probes the comparison boundary.
- The strobe combinations read-plus-drain and enable-write with and without an empty holding register. These show the set-over-clear rule and the one-cycle latency.

Seeded random traffic with sparse, independently enabled causes then reaches mixed patterns that the directed cases leave out. Each result is compared against a bench model of the ranking and of the pending flag.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_THR     = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_TIMEOUT = 4'hC
  } irq_id_e;

  // strobes from control to datapath for the hidden pending flag
  typedef struct packed {
    logic setPend;
    logic clrPend;
  } pend_strobe_t;

  localparam int NUM_SRC = 5;
  localparam logic [3:0] FIFO_TAG = 4'hC;

  // index 0 is the highest rank
  function automatic irq_id_e srcCode(input int idx);
    case (idx)
      0:       return ID_LINE;
      1:       return ID_TIMEOUT;
      2:       return ID_RXDATA;
      3:       return ID_THR;
      default: return ID_MODEM;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic         txDrained,
  input  logic         ierWrite,
  input  logic         thrEmpty,
  input  logic         idRead,
  input  logic         thrWrite,
  output pend_strobe_t strobes
);

  logic setByIer;

  always_comb begin
    setByIer        = ierWrite & thrEmpty;
    strobes.setPend = txDrained | setByIer;
    strobes.clrPend = idRead | thrWrite;
  end

endmodule

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  pend_strobe_t     strobes,
  input  logic [3:0]       ierValue,
  input  logic [3:0]       lineErr,
  input  logic             dataReady,
  input  logic             fifoOn,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrigger,
  input  logic             timeoutPend,
  input  logic [3:0]       modemDelta,
  output logic [7:0]       idCode,
  output logic             irqOut
);

  logic               pendFlag;
  logic [NUM_SRC-1:0] srcActive;
  logic               rxLevelOk;
  irq_id_e            lowCode;
  logic               anyHit;

  // hidden transmit-empty flag: a set request beats a clear request
  always_ff @(posedge clk) begin
    if (rst)                  pendFlag <= 1'b0;
    else if (strobes.setPend) pendFlag <= 1'b1;
    else if (strobes.clrPend) pendFlag <= 1'b0;
  end

  always_comb begin
    rxLevelOk    = !fifoOn || (rxCount >= rxTrigger);
    srcActive[0] = ierValue[2] && (|lineErr);
    srcActive[1] = ierValue[0] && timeoutPend;
    srcActive[2] = ierValue[0] && dataReady && rxLevelOk;
    srcActive[3] = ierValue[1] && pendFlag;
    srcActive[4] = ierValue[3] && (|modemDelta);
  end

  // scan from lowest rank upward so the highest active rank is the last one kept
  always_comb begin
    lowCode = ID_NONE;
    anyHit  = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (srcActive[i]) begin
        lowCode = srcCode(i);
        anyHit  = 1'b1;
      end
    end
  end

  assign idCode = {(fifoOn ? FIFO_TAG : 4'h0), lowCode};
  assign irqOut = anyHit;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       ierValue,
  input  logic [3:0]       lineErr,
  input  logic             dataReady,
  input  logic             fifoOn,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrigger,
  input  logic             timeoutPend,
  input  logic [3:0]       modemDelta,
  input  logic             thrEmpty,
  input  logic             txDrained,
  input  logic             ierWrite,
  input  logic             idRead,
  input  logic             thrWrite,
  output logic [7:0]       idCode,
  output logic             irqOut
);

  pend_strobe_t strobes;

  uart_irq_ctrl u_ctrl (
    .txDrained (txDrained),
    .ierWrite  (ierWrite),
    .thrEmpty  (thrEmpty),
    .idRead    (idRead),
    .thrWrite  (thrWrite),
    .strobes   (strobes)
  );

  uart_irq_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .ierValue    (ierValue),
    .lineErr     (lineErr),
    .dataReady   (dataReady),
    .fifoOn      (fifoOn),
    .rxCount     (rxCount),
    .rxTrigger   (rxTrigger),
    .timeoutPend (timeoutPend),
    .modemDelta  (modemDelta),
    .idCode      (idCode),
    .irqOut      (irqOut)
  );

endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       ierValue,
  input logic [3:0]       lineErr,
  input logic             dataReady,
  input logic             fifoOn,
  input logic [CNT_W-1:0] rxCount,
  input logic [CNT_W-1:0] rxTrigger,
  input logic             timeoutPend,
  input logic [3:0]       modemDelta,
  input logic             thrEmpty,
  input logic             txDrained,
  input logic             ierWrite,
  input logic             idRead,
  input logic             thrWrite,
  input logic [7:0]       idCode,
  input logic             irqOut
);

  AST_LINE_WINS: assert property (@(posedge clk) disable iff (rst)
    (ierValue[2] && (|lineErr)) |-> (idCode[3:0] == 4'h6));  // R2

  AST_TIMEOUT_MASKED: assert property (@(posedge clk) disable iff (rst)
    !ierValue[0] |-> (idCode[3:0] != 4'hC));  // R3

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (ierValue == 4'h0) |-> (!irqOut && idCode[3:0] == 4'h1));  // R7

  AST_IRQ_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
    irqOut |-> (idCode[3:0] != 4'h1));  // R7

  AST_DRAIN_SETS: assert property (@(posedge clk) disable iff (rst)
    txDrained |=> ((ierValue == 4'b0010) -> (idCode[3:0] == 4'h2)));  // R9

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (idRead && !txDrained && !(ierWrite && thrEmpty)) |=> (idCode[3:0] != 4'h2));  // R10

endmodule

bind uart_irq_prio uart_irq_prio_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_uart_irq_prio.sv
module tb_uart_irq_prio;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst;
  logic [3:0]       ierValue, lineErr, modemDelta;
  logic             dataReady, fifoOn, timeoutPend, thrEmpty;
  logic             txDrained, ierWrite, idRead, thrWrite;
  logic [CNT_W-1:0] rxCount, rxTrigger;
  logic [7:0]       idCode;
  logic             irqOut;

  int checks = 0;
  int failures = 0;
  logic modelPend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_prio #(.CNT_W(CNT_W)) dut (.*);

  function automatic logic [3:0] expLow(logic pend);
    if (ierValue[2] && |lineErr)  return 4'h6;
    if (ierValue[0] && timeoutPend) return 4'hC;
    if (ierValue[0] && dataReady && (!fifoOn || rxCount >= rxTrigger)) return 4'h4;
    if (ierValue[1] && pend)      return 4'h2;
    if (ierValue[3] && |modemDelta) return 4'h0;
    return 4'h1;
  endfunction

  function automatic string tagOf(logic [3:0] c);
    case (c)
      4'h6: return "R2";
      4'hC: return "R3";
      4'h4: return "R4";
      4'h2: return "R5";
      4'h0: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic checkFull(string tag, logic [3:0] low);
    check(tag, idCode, {(fifoOn ? 4'hC : 4'h0), low});
    check({tag, "/R7 irq"}, {7'd0, irqOut}, {7'd0, low != 4'h1});
  endtask

  task automatic idle();
    ierValue = 0; lineErr = 0; modemDelta = 0; dataReady = 0; fifoOn = 0;
    timeoutPend = 0; thrEmpty = 0; txDrained = 0; ierWrite = 0; idRead = 0;
    thrWrite = 0; rxCount = 0; rxTrigger = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    txDrained = 0; ierWrite = 0; idRead = 0; thrWrite = 0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    failures++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    #1;
    checkFull("R11 reset", 4'h1);

    // R9: enable write with empty holding register sets pending
    @(negedge clk);
    ierValue = 4'b0010; thrEmpty = 1; ierWrite = 1;
    #1 checkFull("R9 before edge", 4'h1);
    tick();
    checkFull("R9 set by enable write", 4'h2);

    // R10: read cycle shows old value, then clears
    idRead = 1; #1;
    checkFull("R10 during read", 4'h2);
    tick();
    checkFull("R10 after read", 4'h1);

    // R9: enable write without empty status does nothing
    thrEmpty = 0; ierWrite = 1;
    tick();
    checkFull("R9 no set when busy", 4'h1);

    // R10: drain and read in one cycle, set wins
    txDrained = 1; idRead = 1;
    tick();
    checkFull("R10 set wins", 4'h2);
    thrWrite = 1;
    tick();
    checkFull("R10 holding write clears", 4'h1);
    txDrained = 1;
    tick();

    // R1: all causes at once, then strip from the top
    ierValue = 4'hF; lineErr = 4'b0100; timeoutPend = 1; dataReady = 1; modemDelta = 4'b0001;
    #1 checkFull("R1 all active", 4'h6);
    lineErr = 0; #1 checkFull("R1 timeout next", 4'hC);
    timeoutPend = 0; #1 checkFull("R1 data next", 4'h4);
    dataReady = 0; #1 checkFull("R1 thr next", 4'h2);
    ierValue = 4'b1001; #1 checkFull("R1 modem last", 4'h0);

    // R3: timeout masked by receive enable
    ierValue = 4'b1110; timeoutPend = 1; dataReady = 1; modemDelta = 0;
    #1 checkFull("R3 masked timeout", 4'h2);
    timeoutPend = 0; dataReady = 0;

    // R4 / R8: FIFO trigger boundary
    ierValue = 4'b0001; fifoOn = 1; dataReady = 1; rxTrigger = 4; rxCount = 3;
    #1 checkFull("R4 below trigger", 4'h1);
    check("R8 upper nibble", {idCode[7:4], 4'h0}, 8'hC0);
    rxCount = 4; #1 checkFull("R4 at trigger", 4'h4);
    fifoOn = 0; rxCount = 0; #1 checkFull("R4 no fifo", 4'h4);
    check("R8 upper nibble off", {idCode[7:4], 4'h0}, 8'h00);

    // R11: reset mid-run clears pending
    idle();
    ierValue = 4'b0010;
    @(negedge clk); rst = 1;
    tick();
    rst = 0; #1;
    checkFull("R11 reset clears pending", 4'h1);
    modelPend = 0;

    // seeded random traffic
    void'($urandom(32'h1550));
    for (int n = 0; n < 4000; n++) begin
      logic nextPend;
      ierValue    = 4'($urandom);
      lineErr     = ($urandom % 5 == 0) ? 4'($urandom) : 4'h0;
      timeoutPend = ($urandom % 6 == 0);
      dataReady   = ($urandom % 3 == 0);
      fifoOn      = ($urandom % 2 == 0);
      rxCount     = CNT_W'($urandom % 17);
      rxTrigger   = CNT_W'($urandom % 17);
      modemDelta  = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      thrEmpty    = ($urandom % 2 == 0);
      txDrained   = ($urandom % 5 == 0);
      ierWrite    = ($urandom % 5 == 0);
      idRead      = ($urandom % 4 == 0);
      thrWrite    = ($urandom % 6 == 0);
      #1;
      begin
        logic [3:0] e;
        e = expLow(modelPend);
        checkFull(tagOf(e), e);
      end
      if (txDrained || (ierWrite && thrEmpty)) nextPend = 1'b1;
      else if (idRead || thrWrite)             nextPend = 1'b0;
      else                                     nextPend = modelPend;
      @(posedge clk);
      modelPend = nextPend;
      @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule